// File: doc/BRIEF.md
# Call and Interrupt Return Stack Sequencer

This block keeps return frames on a byte-wide stack that lives in data RAM. Each frame is two bytes and holds a 14-bit return program counter together with the carry and zero flags. Four operations are served: interrupt acknowledge and subroutine call each store a frame, and subroutine return and return-from-interrupt each take one back. Every operation uses exactly two memory cycles, addressed through an 8-bit stack pointer that starts at zero and climbs as frames are stored.

The surrounding core raises a request with an operation code and the current program counter and flags. The block runs its state machine, drives the RAM port and ends with a one-cycle `done` pulse. For returns, that pulse also carries write strobes for the program counter and, for return-from-interrupt only, the flags. The block also owns the global interrupt-enable bit. Firmware may load the pointer from the accumulator while the block is idle.

The state machine has six states. `ST_IDLE` waits for work. `ST_PUSH_LO` and `ST_PUSH_HI` write the two bytes of a frame. `ST_POP_HI` and `ST_POP_LO` issue the two reads. `ST_POP_FIN` takes in the last read byte. The transitions are: IDLE to PUSH_LO on an accepted interrupt acknowledge or call; IDLE to POP_HI on an accepted return or return-from-interrupt; PUSH_LO to PUSH_HI; PUSH_HI to IDLE; POP_HI to POP_LO; POP_LO to POP_FIN; and POP_FIN to IDLE.

Top module: `frame_stack_seq`

## Requirements
- R1: After reset the stack pointer reads 0x00, and `ie`, `busy`, `done`, `pc_wr`, `flag_wr`, `pc_out`, `c_out` and `z_out` are all zero.
- R2: `op_kind` encodes 2'b00 interrupt acknowledge, 2'b01 call, 2'b10 return and 2'b11 return-from-interrupt. A request is accepted on a clock edge where `op_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle in which `done` rises.
- R3: A store writes twice. In the first cycle after acceptance it writes byte PC[7:0] at the pointer, then the pointer rises by one. In the second cycle it writes byte {carry in bit 7, zero in bit 6, PC[13:8] in bits 5:0} at the new pointer, then the pointer rises by one again. The block never reads and writes RAM in the same cycle.
- R4: An accepted interrupt acknowledge drives `ie` low from the first cycle after acceptance. A call leaves `ie` unchanged.
- R5: A return-from-interrupt reads address pointer-1 (the high byte) and then pointer-2 (the low byte), one cycle apart, and the pointer falls by two. With `done` it restores the program counter and both flags, raises `pc_wr` and `flag_wr`, and sets `ie`.
- R6: A plain return reads the same two addresses and lowers the pointer by two. It restores only the program counter, with `pc_wr` high and `flag_wr` low. `c_out`, `z_out` and `ie` keep their values.
- R7: `done` is a single-cycle pulse with `busy` low. For stores it comes in the third cycle after acceptance, and for loads in the fourth.
- R8: The pointer wraps modulo 256. A store at 0xFF writes 0xFF and then 0x00. A load at 0x01 reads 0x00 and then 0xFF.
- R9: `sp_wr` loads `acc_in` into the pointer only while the block is idle and `op_valid` is low. While `busy` is high it has no effect. In a cycle where a request is accepted, the request wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | Operation code (see R2) |
| pc_in | input | 14 | Return program counter to store |
| c_in | input | 1 | Carry flag to store |
| z_in | input | 1 | Zero flag to store |
| sp_wr | input | 1 | Load pointer from accumulator |
| acc_in | input | 8 | Accumulator value for pointer load |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |
| pc_out | output | 14 | Restored program counter |
| pc_wr | output | 1 | Program counter restore strobe |
| c_out | output | 1 | Restored carry flag |
| z_out | output | 1 | Restored zero flag |
| flag_wr | output | 1 | Flag restore strobe |
| ie | output | 1 | Global interrupt enable |
| sp_out | output | 8 | Current stack pointer |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read enable |

## Verification
For a store, the bench expects RAM writes in the first and second cycles after the accepting edge and `done` in the third. For a load, it expects reads in the first and second cycles and the restored values with `done` in the fourth. Every expected RAM access and completion is queued in order by the driver, and a monitor compares each one against the port activity at the falling edge of the cycle where it appears. The driver also counts cycles from acceptance to `done`, checks `ie` and `busy` in the first busy cycle, and checks that `done` has dropped one cycle later.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    typedef enum logic [1:0] {
        OP_INTR = 2'b00,
        OP_CALL = 2'b01,
        OP_RET  = 2'b10,
        OP_RETI = 2'b11
    } fstk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_LO = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_POP_HI  = 3'd3,
        ST_POP_LO  = 3'd4,
        ST_POP_FIN = 3'd5
    } fstk_state_e;

    function automatic logic op_is_store(input fstk_op_e op);
        return (op == OP_INTR) || (op == OP_CALL);
    endfunction

endpackage

// File: rtl/fstk_ptr.sv
module fstk_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_dn
);
    logic [AW-1:0] sp_q;

    // Width of sp_q gives the modulo wrap for free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= load_val;
        end else if (inc) begin
            sp_q <= sp_q + AW'(1);
        end else if (dec) begin
            sp_q <= sp_q - AW'(1);
        end
    end

    assign sp    = sp_q;
    assign sp_dn = sp_q - AW'(1);
endmodule

// File: rtl/fstk_frame.sv
module fstk_frame #(
    parameter int PC_W = 14,
    parameter int DW   = 8
) (
    input  logic [PC_W-1:0] pk_pc,
    input  logic            pk_c,
    input  logic            pk_z,
    output logic [DW-1:0]   pk_lo,
    output logic [DW-1:0]   pk_hi,
    input  logic [DW-1:0]   up_lo,
    input  logic [DW-1:0]   up_hi,
    output logic [PC_W-1:0] up_pc,
    output logic            up_c,
    output logic            up_z
);
    localparam int HI_W = PC_W - DW;
    localparam int PAD  = DW - 2 - HI_W;

    assign pk_lo = pk_pc[DW-1:0];
    assign up_c  = up_hi[DW-1];
    assign up_z  = up_hi[DW-2];
    assign up_pc = {up_hi[HI_W-1:0], up_lo};

    generate
        if (PAD > 0) begin : g_pad
            assign pk_hi = {pk_c, pk_z, {PAD{1'b0}}, pk_pc[PC_W-1:DW]};
        end else begin : g_tight
            assign pk_hi = {pk_c, pk_z, pk_pc[PC_W-1:DW]};
        end
    endgenerate
endmodule

// File: rtl/frame_stack_seq.sv
module frame_stack_seq
    import fstk_pkg::*;
#(
    parameter int PC_W = 14,
    parameter int DW   = 8,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [PC_W-1:0] pc_in,
    input  logic            c_in,
    input  logic            z_in,
    input  logic            sp_wr,
    input  logic [DW-1:0]   acc_in,
    input  logic [DW-1:0]   ram_rdata,
    output logic            busy,
    output logic            done,
    output logic [PC_W-1:0] pc_out,
    output logic            pc_wr,
    output logic            c_out,
    output logic            z_out,
    output logic            flag_wr,
    output logic            ie,
    output logic [AW-1:0]   sp_out,
    output logic [AW-1:0]   ram_addr,
    output logic            ram_we,
    output logic [DW-1:0]   ram_wdata,
    output logic            ram_re
);
    fstk_state_e state_q, state_d;
    fstk_op_e    kind_q;
    fstk_op_e    req_op;

    logic [DW-1:0]   lo_q, hi_q, rd_hi_q;
    logic [PC_W-1:0] pc_q;
    logic            c_q, z_q, ie_q;
    logic            done_q, pcw_q, flw_q;

    logic            accept, sp_ld, ptr_inc, ptr_dec;
    logic [AW-1:0]   sp, sp_dn;
    logic [DW-1:0]   pk_lo, pk_hi;
    logic [PC_W-1:0] up_pc;
    logic            up_c, up_z;

    assign req_op = fstk_op_e'(op_kind);
    assign accept = op_valid && (state_q == ST_IDLE);
    assign sp_ld  = sp_wr && !op_valid && (state_q == ST_IDLE);

    fstk_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ptr_inc),
        .dec      (ptr_dec),
        .load     (sp_ld),
        .load_val (AW'(acc_in)),
        .sp       (sp),
        .sp_dn    (sp_dn)
    );

    fstk_frame #(.PC_W(PC_W), .DW(DW)) u_frame (
        .pk_pc (pc_in),
        .pk_c  (c_in),
        .pk_z  (z_in),
        .pk_lo (pk_lo),
        .pk_hi (pk_hi),
        .up_lo (ram_rdata),
        .up_hi (rd_hi_q),
        .up_pc (up_pc),
        .up_c  (up_c),
        .up_z  (up_z)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = op_is_store(req_op) ? ST_PUSH_LO : ST_POP_HI;
                end
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_IDLE;
            ST_POP_HI:  state_d = ST_POP_LO;
            ST_POP_LO:  state_d = ST_POP_FIN;
            ST_POP_FIN: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OP_INTR;
            lo_q    <= '0;
            hi_q    <= '0;
            rd_hi_q <= '0;
            pc_q    <= '0;
            c_q     <= 1'b0;
            z_q     <= 1'b0;
            ie_q    <= 1'b0;
            done_q  <= 1'b0;
            pcw_q   <= 1'b0;
            flw_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pcw_q  <= 1'b0;
            flw_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        kind_q <= req_op;
                        lo_q   <= pk_lo;
                        hi_q   <= pk_hi;
                        if (req_op == OP_INTR) begin
                            ie_q <= 1'b0;
                        end
                    end
                end
                ST_PUSH_LO: begin
                end
                ST_PUSH_HI: begin
                    done_q <= 1'b1;
                end
                ST_POP_HI: begin
                end
                ST_POP_LO: begin
                    rd_hi_q <= ram_rdata;
                end
                ST_POP_FIN: begin
                    pc_q   <= up_pc;
                    pcw_q  <= 1'b1;
                    done_q <= 1'b1;
                    if (kind_q == OP_RETI) begin
                        c_q   <= up_c;
                        z_q   <= up_z;
                        ie_q  <= 1'b1;
                        flw_q <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Output and memory-port decode
    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = sp;
        ram_wdata = '0;
        ptr_inc   = 1'b0;
        ptr_dec   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PUSH_LO: begin
                ram_we    = 1'b1;
                ram_wdata = lo_q;
                ptr_inc   = 1'b1;
            end
            ST_PUSH_HI: begin
                ram_we    = 1'b1;
                ram_wdata = hi_q;
                ptr_inc   = 1'b1;
            end
            ST_POP_HI, ST_POP_LO: begin
                ram_re   = 1'b1;
                ram_addr = sp_dn;
                ptr_dec  = 1'b1;
            end
            ST_POP_FIN: begin
            end
            default: begin
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign pc_out  = pc_q;
    assign pc_wr   = pcw_q;
    assign c_out   = c_q;
    assign z_out   = z_q;
    assign flag_wr = flw_q;
    assign ie      = ie_q;
    assign sp_out  = sp;
endmodule

// File: rtl/fstk_chk.sv
module fstk_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [1:0]    op_kind,
    input logic          busy,
    input logic          done,
    input logic          ram_we,
    input logic          ram_re,
    input logic [AW-1:0] sp_out,
    input logic          ie,
    input logic          pc_wr,
    input logic          flag_wr
);
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);

    a_r3_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp_out == AW'($past(sp_out) + AW'(1))));

    a_r3_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    a_r4_intr_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_kind == 2'b00) |=> !ie);

    a_r5_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (sp_out == AW'($past(sp_out) - AW'(1))));

    a_r6_flags_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (pc_wr && done));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind frame_stack_seq fstk_chk #(.AW(AW)) u_fstk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .busy     (busy),
    .done     (done),
    .ram_we   (ram_we),
    .ram_re   (ram_re),
    .sp_out   (sp_out),
    .ie       (ie),
    .pc_wr    (pc_wr),
    .flag_wr  (flag_wr)
);

// File: tb/tb_frame_stack_seq.sv
`timescale 1ns/100ps
module tb_frame_stack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [13:0] pc_in = '0;
    logic        c_in = 1'b0, z_in = 1'b0;
    logic        sp_wr = 1'b0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  ram_rdata;
    logic        busy, done, pc_wr, c_out, z_out, flag_wr, ie;
    logic [13:0] pc_out;
    logic [7:0]  sp_out, ram_addr, ram_wdata;
    logic        ram_we, ram_re;

    always #2.5 clk = ~clk;

    frame_stack_seq dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .pc_in(pc_in), .c_in(c_in), .z_in(z_in), .sp_wr(sp_wr), .acc_in(acc_in),
        .ram_rdata(ram_rdata), .busy(busy), .done(done), .pc_out(pc_out),
        .pc_wr(pc_wr), .c_out(c_out), .z_out(z_out), .flag_wr(flag_wr), .ie(ie),
        .sp_out(sp_out), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_re(ram_re)
    );

    // RAM with one-cycle read latency
    logic [7:0] mem [256];
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        ram_rdata = 8'h00;
    end
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    // Scoreboard
    localparam logic [1:0] EV_WR = 2'd0, EV_RD = 2'd1, EV_DONE = 2'd2;
    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [7:0]  data;
        logic [26:0] res;
    } ev_t;
    ev_t   exp_q[$];
    string tag_q[$];

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // Bench model state
    logic [7:0]  m_sp = 8'h00;
    logic [7:0]  m_mem [256];
    logic [13:0] m_pc = '0;
    logic        m_c = 0, m_z = 0, m_ie = 0;
    initial for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [26:0] pack_res(input logic [13:0] pc, input logic c, input logic z,
                                            input logic pw, input logic fw, input logic e,
                                            input logic [7:0] sp);
        return {pc, c, z, pw, fw, e, sp};
    endfunction

    task automatic push(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d,
                        input logic [26:0] r, input string t);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.res = r;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && (ram_we || ram_re || done)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected event", {29'd0, ram_we, ram_re, done}, 32'd0);
            end else begin
                ev_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.kind == EV_WR)
                    chk(ram_we && ram_addr == e.addr && ram_wdata == e.data, t,
                        {15'd0, ram_we, ram_addr, ram_wdata}, {15'd0, 1'b1, e.addr, e.data});
                else if (e.kind == EV_RD)
                    chk(ram_re && ram_addr == e.addr, t,
                        {23'd0, ram_re, ram_addr}, {23'd0, 1'b1, e.addr});
                else begin
                    logic [26:0] act;
                    act = pack_res(pc_out, c_out, z_out, pc_wr, flag_wr, ie, sp_out);
                    chk(done && act == e.res, t, {4'd0, done, act}, {4'd0, 1'b1, e.res});
                end
            end
        end
    end

    // Driver: issues one operation and queues what it must produce.
    task automatic do_op(input logic [1:0] k, input logic [13:0] pc, input logic c, input logic z,
                         input bit same_wr, input bit busy_wr, input string t);
        logic [7:0] lo, hi;
        bit         store;
        logic       ie_before;
        int         cycles;
        store = (k == 2'b00) || (k == 2'b01);
        ie_before = m_ie;
        if (store) begin
            lo = pc[7:0];
            hi = {c, z, pc[13:8]};
            push(EV_WR, m_sp, lo, '0, t);
            m_mem[m_sp] = lo;
            m_sp = m_sp + 8'd1;
            push(EV_WR, m_sp, hi, '0, t);
            m_mem[m_sp] = hi;
            m_sp = m_sp + 8'd1;
            if (k == 2'b00) m_ie = 0;
            push(EV_DONE, '0, '0, pack_res(m_pc, m_c, m_z, 1'b0, 1'b0, m_ie, m_sp), t);
        end else begin
            push(EV_RD, m_sp - 8'd1, '0, '0, t);
            push(EV_RD, m_sp - 8'd2, '0, '0, t);
            hi = m_mem[m_sp - 8'd1];
            lo = m_mem[m_sp - 8'd2];
            m_sp = m_sp - 8'd2;
            m_pc = {hi[5:0], lo};
            if (k == 2'b11) begin
                m_c = hi[7];
                m_z = hi[6];
                m_ie = 1;
            end
            push(EV_DONE, '0, '0,
                 pack_res(m_pc, m_c, m_z, 1'b1, (k == 2'b11), m_ie, m_sp), t);
        end

        @(negedge clk);
        op_valid = 1; op_kind = k; pc_in = pc; c_in = c; z_in = z;
        sp_wr = same_wr; acc_in = 8'h77;
        @(negedge clk);
        op_valid = 0; sp_wr = 0;
        cycles = 1;
        chk(busy == 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
        if (k == 2'b00) chk(ie == 1'b0, "R4 intr clears ie", {31'd0, ie}, 32'd0);
        if (k == 2'b01) chk(ie == ie_before, "R4 call keeps ie", {31'd0, ie}, {31'd0, ie_before});
        if (busy_wr) begin
            sp_wr = 1; acc_in = 8'h55;
        end
        while (!done && cycles < 12) begin
            @(negedge clk);
            sp_wr = 0;
            cycles++;
        end
        chk(cycles == (store ? 3 : 4), "R7 done latency", cycles, store ? 3 : 4);
        chk(busy == 1'b0, "R7 busy low with done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic load_sp(input logic [7:0] v);
        @(negedge clk);
        sp_wr = 1; acc_in = v;
        @(negedge clk);
        sp_wr = 0;
        m_sp = v;
        chk(sp_out == v, "R9 idle pointer load", {24'd0, sp_out}, {24'd0, v});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sp_out == 8'h00, "R1 sp", {24'd0, sp_out}, 0);
        chk({ie, busy, done, pc_wr, flag_wr, c_out, z_out} == 7'd0, "R1 flags",
            {25'd0, ie, busy, done, pc_wr, flag_wr, c_out, z_out}, 0);
        chk(pc_out == 14'd0, "R1 pc_out", {18'd0, pc_out}, 0);

        do_op(2'b01, 14'h2ABC, 1'b1, 1'b0, 0, 0, "R3 call frame");
        do_op(2'b00, 14'h0155, 1'b0, 1'b1, 0, 0, "R3 R4 intr frame");
        do_op(2'b11, 14'h0000, 1'b0, 1'b0, 0, 0, "R5 reti");
        do_op(2'b00, 14'h3F01, 1'b1, 1'b1, 0, 0, "R4 intr with ie set");
        do_op(2'b11, 14'h0000, 1'b0, 1'b0, 0, 0, "R5 reti second");
        do_op(2'b10, 14'h1111, 1'b0, 1'b0, 0, 0, "R6 ret keeps flags");
        chk(sp_out == 8'h00, "R6 pointer back to zero", {24'd0, sp_out}, 0);

        load_sp(8'hFF);
        do_op(2'b00, 14'h1A5C, 1'b0, 1'b1, 0, 0, "R8 wrap store");
        chk(sp_out == 8'h01, "R8 wrapped pointer", {24'd0, sp_out}, 32'h01);
        do_op(2'b11, 14'h0000, 1'b0, 1'b0, 0, 0, "R8 wrap load");
        chk(sp_out == 8'hFF, "R8 pointer unwrapped", {24'd0, sp_out}, 32'hFF);

        load_sp(8'h10);
        do_op(2'b01, 14'h0A0B, 1'b1, 1'b1, 1, 1, "R9 load ignored");
        chk(sp_out == 8'h12, "R9 pointer after ignored loads", {24'd0, sp_out}, 32'h12);
        do_op(2'b10, 14'h0000, 1'b0, 1'b0, 0, 0, "R6 ret after call");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            report();
        end
    end
endmodule